// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of several devices may drive a shared bus. Each device slot raises a request. The requests of one chain are folded into a single active-low request line, in the way an open-drain line is pulled low. A single grant enters the chain at slot 0 and moves toward the far end. The first slot that is requesting absorbs the grant and becomes the bus owner. A slot with no request passes the grant to the next slot, so the lowest-numbered requester always wins.

An optional upper chain (parameter `TWO_LEVEL`) has its own request line and grant path. It is served ahead of the lower chain.

The `decentral` pin selects the decentralized scheme. In that scheme the grant is present at the head of the chain whenever the bus is idle, whether or not anyone is requesting. A device still takes the bus only when it holds the grant and the shared busy flag is clear. In both schemes the owner keeps the bus for as long as it holds its request. Busy stays high for one cycle after the release, so that the bus can settle before the next grant.

Top module: `daisy_arbiter`

## Requirements
- R1: `busreq_lo_n` is low exactly when any bit of `req_lo` is high. `busreq_hi_n` is low exactly when any bit of `req_hi` is high and `TWO_LEVEL` is 1.
- R2: While `busy` is low, the grant seen by slot i of a chain (`gnt_lo[i]`, `gnt_hi[i]`) is high if the chain head holds the grant and no slot below i requests. While `busy` is high, every grant is low. In central mode (`decentral`=0), a chain head holds the grant only if some slot of that chain requests.
- R3: When the bus is idle, the requesting slot with the lowest index takes ownership at the next clock edge, and `busy` rises at that same edge.
- R4: Any upper-chain request blocks the lower chain head. If both chains request while the bus is idle, the owner comes from `req_hi`.
- R5: With `decentral`=1 and the bus idle, each chain head holds the grant even with no request, so every `gnt` bit of a chain with no requester is high. The lower head is still blocked by upper requests.
- R6: While the owner keeps its request high, `own_hi`/`own_lo` do not change, and requests from other slots are ignored.
- R7: At the first edge at which the owner's request is low, ownership clears while `busy` stays high. At the next edge `busy` falls.
- R8: The concatenation {`own_hi`,`own_lo`} has at most one bit set, and any set bit implies `busy`=1.
- R9: The active-low asynchronous reset `rst_n` clears ownership and busy immediately.
- R10: With `TWO_LEVEL`=0, `req_hi` is ignored: `busreq_hi_n` stays high, `gnt_hi` and `own_hi` stay zero, and the lower chain arbitrates alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decentral | input | 1 | 1 selects the decentralized busy-line scheme |
| req_hi | input | N | Upper-chain slot requests, bit i is slot i |
| req_lo | input | N | Lower-chain slot requests, bit i is slot i |
| busreq_hi_n | output | 1 | Combined active-low upper request line |
| busreq_lo_n | output | 1 | Combined active-low lower request line |
| gnt_hi | output | N | Grant reaching each upper slot |
| gnt_lo | output | N | Grant reaching each lower slot |
| own_hi | output | N | One-hot upper owner |
| own_lo | output | N | One-hot lower owner |
| busy | output | 1 | Shared bus-busy flag |

## Verification
The bench builds the main instance with N=4 and TWO_LEVEL=1. This lets it reach every position in the grant ripple, simultaneous requests in both chains, and a request that arrives during the busy tail. A second instance uses TWO_LEVEL=0 and shares the same stimulus. It shows that upper requests are ignored while the lower chain still grants. Both the central scheme and the decentralized scheme run on the main instance, and idle grants with no requester show the difference between them.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
  typedef enum logic {
    SCHEME_CENTRAL     = 1'b0,
    SCHEME_SHARED_BUSY = 1'b1
  } scheme_e;

  // Head grant of a chain: idle bus, not blocked, and either a local
  // requester or the decentralized scheme where the grant idles present.
  function automatic logic head_grant(input logic idle, input logic blocked,
                                      input logic any_req, input scheme_e sch);
    return idle & ~blocked & ((sch == SCHEME_SHARED_BUSY) | any_req);
  endfunction
endpackage

// File: rtl/daisy_slot.sv
module daisy_slot (
  input  logic grant_in,
  input  logic req,
  output logic grant_out,
  output logic take
);
  assign take      = grant_in & req;
  assign grant_out = grant_in & ~req;
endmodule

// File: rtl/daisy_chain.sv
module daisy_chain #(
  parameter int N = 4
) (
  input  logic         head,
  input  logic [N-1:0] req,
  output logic [N-1:0] seen,
  output logic [N-1:0] take
);
  logic [N:0] link;
  assign link[0] = head;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign seen[i] = link[i];
    daisy_slot u_slot (
      .grant_in (link[i]),
      .req      (req[i]),
      .grant_out(link[i+1]),
      .take     (take[i])
    );
  end
endmodule

// File: rtl/arb_owner.sv
module arb_owner #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] take,
  input  logic [W-1:0] req,
  output logic [W-1:0] own,
  output logic         busy
);
  logic has_owner, still_held;
  assign has_owner  = |own;
  assign still_held = |(own & req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own  <= '0;
      busy <= 1'b0;
    end else if (!busy) begin
      if (|take) begin
        own  <= take;
        busy <= 1'b1;
      end
    end else if (has_owner) begin
      if (!still_held) own <= '0;
    end else begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter
  import daisy_arb_pkg::*;
#(
  parameter int N         = 4,
  parameter int TWO_LEVEL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         decentral,
  input  logic [N-1:0] req_hi,
  input  logic [N-1:0] req_lo,
  output logic         busreq_hi_n,
  output logic         busreq_lo_n,
  output logic [N-1:0] gnt_hi,
  output logic [N-1:0] gnt_lo,
  output logic [N-1:0] own_hi,
  output logic [N-1:0] own_lo,
  output logic         busy
);
  localparam int W = 2 * N;

  scheme_e      scheme;
  logic [N-1:0] req_hi_eff;
  logic         any_hi, any_lo, idle;
  logic         head_hi, head_lo;
  logic [N-1:0] take_hi, take_lo;
  logic [W-1:0] own_all;

  assign scheme = scheme_e'(decentral);

  if (TWO_LEVEL != 0) begin : g_two
    assign req_hi_eff = req_hi;
  end else begin : g_one
    assign req_hi_eff = '0;
  end

  assign any_hi      = |req_hi_eff;
  assign any_lo      = |req_lo;
  assign busreq_hi_n = ~any_hi;
  assign busreq_lo_n = ~any_lo;
  assign idle        = ~busy;

  assign head_hi = (TWO_LEVEL != 0) ? head_grant(idle, 1'b0, any_hi, scheme) : 1'b0;
  assign head_lo = head_grant(idle, any_hi, any_lo, scheme);

  daisy_chain #(.N(N)) u_chain_hi (
    .head(head_hi), .req(req_hi_eff), .seen(gnt_hi), .take(take_hi)
  );

  daisy_chain #(.N(N)) u_chain_lo (
    .head(head_lo), .req(req_lo), .seen(gnt_lo), .take(take_lo)
  );

  arb_owner #(.W(W)) u_owner (
    .clk  (clk),
    .rst_n(rst_n),
    .take ({take_hi, take_lo}),
    .req  ({req_hi_eff, req_lo}),
    .own  (own_all),
    .busy (busy)
  );

  assign own_hi = own_all[W-1:N];
  assign own_lo = own_all[N-1:0];
endmodule

// File: rtl/daisy_arbiter_chk.sv
module daisy_arbiter_chk #(
  parameter int N         = 4,
  parameter int TWO_LEVEL = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_hi,
  input logic [N-1:0] req_lo,
  input logic [N-1:0] gnt_hi,
  input logic [N-1:0] gnt_lo,
  input logic [N-1:0] own_hi,
  input logic [N-1:0] own_lo,
  input logic         busy
);
  logic held, owned;
  assign owned = |{own_hi, own_lo};
  assign held  = |(own_lo & req_lo) || ((TWO_LEVEL != 0) && |(own_hi & req_hi));

  assert_owner_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({own_hi, own_lo}));
  assert_owner_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    owned |-> busy);
  assert_grant_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({gnt_hi, gnt_lo} == '0));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable({own_hi, own_lo}));
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !held) |=> (({own_hi, own_lo} == '0) && busy));
  assert_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !owned) |=> !busy);
  assert_hi_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((TWO_LEVEL != 0) && !busy && (|req_hi)) |=> (own_lo == '0));
  assert_flat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (TWO_LEVEL == 0) |-> ((own_hi == '0) && (gnt_hi == '0)));
endmodule

bind daisy_arbiter daisy_arbiter_chk #(.N(N), .TWO_LEVEL(TWO_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
  .gnt_hi(gnt_hi), .gnt_lo(gnt_lo), .own_hi(own_hi), .own_lo(own_lo),
  .busy(busy)
);

// File: tb/daisy_arbiter_bench.sv
module daisy_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       decentral = 1'b0;
  logic [3:0] req_hi = '0, req_lo = '0;
  logic       brh_n, brl_n, busy;
  logic [3:0] gnt_hi, gnt_lo, own_hi, own_lo;
  logic       f_brh_n, f_brl_n, f_busy;
  logic [3:0] f_gnt_hi, f_gnt_lo, f_own_hi, f_own_lo;
  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] m_exp;
  string      m_tag;

  always #5 clk = ~clk;

  daisy_arbiter #(.N(4), .TWO_LEVEL(1)) u_daisy_arbiter (
    .clk(clk), .rst_n(rst_n), .decentral(decentral), .req_hi(req_hi), .req_lo(req_lo),
    .busreq_hi_n(brh_n), .busreq_lo_n(brl_n), .gnt_hi(gnt_hi), .gnt_lo(gnt_lo),
    .own_hi(own_hi), .own_lo(own_lo), .busy(busy));

  daisy_arbiter #(.N(4), .TWO_LEVEL(0)) u_daisy_arbiter_flat (
    .clk(clk), .rst_n(rst_n), .decentral(decentral), .req_hi(req_hi), .req_lo(req_lo),
    .busreq_hi_n(f_brh_n), .busreq_lo_n(f_brl_n), .gnt_hi(f_gnt_hi), .gnt_lo(f_gnt_lo),
    .own_hi(f_own_hi), .own_lo(f_own_lo), .busy(f_busy));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // driver: wait one edge, queue the state expected after it
  task automatic cyc(input logic [3:0] hi, input logic [3:0] lo, input logic b,
                     input string tag);
    @(posedge clk);
    #1;
    exp_q.push_back({hi, lo, b});
    tag_q.push_back(tag);
  endtask

  task automatic drive(input logic [3:0] hi, input logic [3:0] lo, input logic dec);
    req_hi = hi; req_lo = lo; decentral = dec;
    #1;
  endtask

  // monitor: compare queued expectations after each edge
  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      chk(m_tag, {23'd0, own_hi, own_lo, busy}, {23'd0, m_exp});
    end
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    chk("R9 reset owner/busy", {own_hi, own_lo, busy}, 9'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // central, no requests: no grants anywhere
    drive(4'b0000, 4'b0000, 1'b0);
    chk("R2 central idle no grant", {gnt_hi, gnt_lo}, 8'h00);
    chk("R1 lines idle high", {brh_n, brl_n}, 2'b11);

    // single lower requester at slot 2
    drive(4'b0000, 4'b0100, 1'b0);
    chk("R1 lower line low", brl_n, 1'b0);
    chk("R2 ripple to slot2", gnt_lo, 4'b0111);
    chk("R2 upper chain dark", gnt_hi, 4'b0000);
    cyc(4'b0000, 4'b0100, 1'b1, "R3 slot2 owns");
    #1 chk("R2 no grant while busy", gnt_lo, 4'b0000);

    // slot0 arrives while slot2 holds
    drive(4'b0000, 4'b0101, 1'b0);
    cyc(4'b0000, 4'b0100, 1'b1, "R6 owner holds");
    drive(4'b0000, 4'b0001, 1'b0);
    cyc(4'b0000, 4'b0000, 1'b1, "R7 release keeps busy");
    cyc(4'b0000, 4'b0000, 1'b0, "R7 busy falls");
    cyc(4'b0000, 4'b0001, 1'b1, "R3 waiting slot0 owns");
    drive(4'b0000, 4'b0000, 1'b0);
    cyc(4'b0000, 4'b0000, 1'b1, "R7 release");
    cyc(4'b0000, 4'b0000, 1'b0, "R7 idle");

    // simultaneous slots 1 and 3
    drive(4'b0000, 4'b1010, 1'b0);
    chk("R2 stop at slot1", gnt_lo, 4'b0011);
    cyc(4'b0000, 4'b0010, 1'b1, "R3 lowest index wins");
    drive(4'b0000, 4'b1000, 1'b0);
    cyc(4'b0000, 4'b0000, 1'b1, "R7 release");
    cyc(4'b0000, 4'b0000, 1'b0, "R7 idle");
    cyc(4'b0000, 4'b1000, 1'b1, "R3 slot3 served");
    drive(4'b0000, 4'b0000, 1'b0);
    cyc(4'b0000, 4'b0000, 1'b1, "R7 release");
    cyc(4'b0000, 4'b0000, 1'b0, "R7 idle");

    // both chains at once
    drive(4'b0100, 4'b0001, 1'b0);
    chk("R4 lower head blocked", gnt_lo, 4'b0000);
    chk("R1 upper line low", brh_n, 1'b0);
    chk("R10 flat upper line high", f_brh_n, 1'b1);
    chk("R10 flat lower grant", f_gnt_lo, 4'b0001);
    cyc(4'b0100, 4'b0000, 1'b1, "R4 upper chain first");
    #1;
    chk("R10 flat lower owns", {f_own_hi, f_own_lo}, 8'h01);
    chk("R10 flat upper grant dark", f_gnt_hi, 4'b0000);
    drive(4'b0000, 4'b0000, 1'b0);
    cyc(4'b0000, 4'b0000, 1'b1, "R7 release");
    cyc(4'b0000, 4'b0000, 1'b0, "R7 idle");

    // decentralized scheme
    drive(4'b0000, 4'b0000, 1'b1);
    chk("R5 idle grant upper", gnt_hi, 4'b1111);
    chk("R5 idle grant lower", gnt_lo, 4'b1111);
    drive(4'b0001, 4'b0000, 1'b1);
    chk("R5 lower blocked by upper", gnt_lo, 4'b0000);
    drive(4'b0000, 4'b0010, 1'b1);
    chk("R5 grant stops at slot1", gnt_lo, 4'b0011);
    cyc(4'b0000, 4'b0010, 1'b1, "R5 slot1 owns");
    #1 chk("R5 no grant while busy", gnt_hi, 4'b0000);
    drive(4'b0000, 4'b0000, 1'b1);
    cyc(4'b0000, 4'b0000, 1'b1, "R7 release");
    cyc(4'b0000, 4'b0000, 1'b0, "R7 idle");

    // reset while owning
    drive(4'b0000, 4'b0001, 1'b0);
    cyc(4'b0000, 4'b0001, 1'b1, "R3 slot0 owns");
    #4;
    rst_n = 1'b0;
    #1;
    chk("R9 async clear", {own_hi, own_lo, busy}, 9'd0);
    chk("R9 flat async clear", {f_own_hi, f_own_lo, f_busy}, 9'd0);
    drive(4'b0000, 4'b0000, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule